// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 memory interface out of reset without any processor help. Once reset is released it waits a settle interval and switches the memory clock on. It then pulses the PHY reset and starts PHY calibration, and plays a fixed twelve-step script of mode-register and maintenance commands into the controller's command register. It finishes by loading the timing, latency and configuration registers from its inputs and raises `done`. Every action is one write on a simple address/data port.

The settle interval is `WAIT_CYCLES` clock cycles. It is set from the clock frequency so that it covers at least 200 µs, which is 50000 cycles at 250 MHz. The same interval follows the clock enable, the calibration start and every script command. Register addresses are `BASE_ADDR` plus fixed offsets: clock-enable 0x00, PHY control 0x04, command 0x08, timing 0x0C, latency 0x10, configuration 0x14.

States: `ST_WAIT_CLK` (settle) → `ST_CLK_ON` (clock enable write) → `ST_WAIT_PHY` → `ST_PHY_RST` (PHY and calibration reset write) → `ST_PHY_CAL` (calibration start write) → `ST_WAIT_CAL` → `ST_CMD` (command write) ⇄ `ST_WAIT_CMD` (post-command wait, twelve rounds) → `ST_TIMING` → `ST_LATENCY` → `ST_CONFIG` → `ST_DONE`. The write states move on only when `bus_ready` is high. The wait states move on when the interval expires. `ST_WAIT_CMD` goes back to `ST_CMD` until the last command, then goes to `ST_TIMING`. `ST_DONE` goes to `ST_WAIT_CLK` on `start`.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is held and right after it, `wr_en` and `done` are 0. The first write becomes visible exactly `WAIT_CYCLES` clock edges after reset release.
- R2: The first write goes to offset 0x00 with data 0x0000_0001, which sets the clock-enable bit 0.
- R3: The PHY is started by two writes to offset 0x04 on back-to-back cycles. The first has data 0x3 (bit 0 PHY reset, bit 1 calibration reset). The second has data 0x4 (bit 2 calibration start only).
- R4: Each command write goes to offset 0x08 with bits 31:24 zero, the opcode in bits 23:16 and the argument in bits 15:0. The opcodes are: deselect 0x00, precharge 0x01, refresh 0x02, MRS 0x03, EMRS 0x04, EMRS2 0x05, EMRS3 0x06.
- R5: The commands, as opcode/argument, come out in this order: deselect/0, precharge/0x0400 (all banks), EMRS2/0, EMRS3/0, EMRS/0x0001 (DLL enable), MRS/0x0100 (DLL reset), precharge/0x0400, refresh/0, refresh/0, MRS/mode, EMRS/0x0381 (OCD default 0x0380 with DLL enable), EMRS/final.
- R6: The argument of the second MRS is `mode_cfg[15:0]`. The final EMRS argument is the bitwise OR of 0x0200 (OCD exit), 0x0001 (DLL enable) and `mode_cfg[31:16]`.
- R7: Exactly `WAIT_CYCLES` idle cycles separate the accepted clock-enable write, the accepted calibration-start write and every accepted command write from the next write.
- R8: After the last wait the timing (0x0C), latency (0x10) and configuration (0x14) writes follow on back-to-back cycles, carrying `timing_cfg`, `latency_cfg` and `ctrl_cfg`.
- R9: While `wr_en` is high and `bus_ready` is low, the write stays presented with unchanged address and data, and the sequence does not advance.
- R10: `done` rises on the cycle after the configuration write is accepted. It stays high with no further writes until reset or `start`.
- R11: `start` while `done` is high reruns the whole sequence from the settle wait. The first write then appears `WAIT_CYCLES` edges after the edge that took `start`. `start` while the sequence runs has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Rerun request, honoured only when done |
| bus_ready | input | 1 | Register port accepts the presented write |
| mode_cfg | input | 32 | Mode value: low half to MRS, high half to final EMRS |
| timing_cfg | input | 32 | Data for the timing register |
| latency_cfg | input | 32 | Data for the latency register |
| ctrl_cfg | input | 32 | Data for the configuration register |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Write data |
| done | output | 1 | Initialization complete |

## Verification
The bench builds the sequencer with `WAIT_CYCLES` = 20 instead of the real 50000. This brings the full eighteen-write run, its reruns and a mid-run reset within a few thousand cycles, while every wait can still be counted exactly. `BASE_ADDR` is set to 0x8000_0000 so that address offsets are checked on top of a non-zero base. The mode value 0x00A5_0642 has bit 0 set in its upper half, which overlaps the DLL-enable bit, so only a true OR produces the expected final EMRS argument.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    typedef enum logic [3:0] {
        ST_WAIT_CLK,
        ST_CLK_ON,
        ST_WAIT_PHY,
        ST_PHY_RST,
        ST_PHY_CAL,
        ST_WAIT_CAL,
        ST_CMD,
        ST_WAIT_CMD,
        ST_TIMING,
        ST_LATENCY,
        ST_CONFIG,
        ST_DONE
    } seq_state_t;

    // Register offsets from the controller base
    localparam logic [31:0] OFF_CLK_EN   = 32'h00;
    localparam logic [31:0] OFF_PHY_CTRL = 32'h04;
    localparam logic [31:0] OFF_CMD      = 32'h08;
    localparam logic [31:0] OFF_TIMING   = 32'h0C;
    localparam logic [31:0] OFF_LATENCY  = 32'h10;
    localparam logic [31:0] OFF_CONFIG   = 32'h14;

    // Control bits
    localparam int CLK_EN_BIT    = 0;
    localparam int PHY_RST_BIT   = 0;
    localparam int CAL_RST_BIT   = 1;
    localparam int CAL_START_BIT = 2;

    // Command opcodes
    localparam logic [7:0] OP_DESEL = 8'h00;
    localparam logic [7:0] OP_PRE   = 8'h01;
    localparam logic [7:0] OP_REF   = 8'h02;
    localparam logic [7:0] OP_MRS   = 8'h03;
    localparam logic [7:0] OP_EMRS  = 8'h04;
    localparam logic [7:0] OP_EMRS2 = 8'h05;
    localparam logic [7:0] OP_EMRS3 = 8'h06;

    // Argument flags
    localparam logic [15:0] ARG_PRE_ALL  = 16'h0400;
    localparam logic [15:0] ARG_DLL_RST  = 16'h0100;
    localparam logic [15:0] ARG_DLL_EN   = 16'h0001;
    localparam logic [15:0] ARG_OCD_DFLT = 16'h0380;
    localparam logic [15:0] ARG_OCD_EXIT = 16'h0200;

    localparam int NUM_CMDS = 12;

    function automatic logic [31:0] cmd_word(input logic [7:0] op, input logic [15:0] arg);
        return {8'h00, op, arg};
    endfunction

endpackage

// File: rtl/ddr2_init_wait.sv
module ddr2_init_wait #(
    parameter int WAIT_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign expired = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (run && !expired)
            cnt <= cnt + 1'b1;
        else
            cnt <= '0;
    end

    // R7: the interval counter never runs past its terminal value
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R7: an interrupted wait restarts from zero
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);

endmodule

// File: rtl/ddr2_init_script.sv
module ddr2_init_script
    import ddr2_init_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      mode_cfg,
    output logic [31:0]      word
);
    logic [15:0] final_arg;

    assign final_arg = ARG_OCD_EXIT | ARG_DLL_EN | mode_cfg[31:16];

    always_comb begin
        case (int'(idx))
            0:       word = cmd_word(OP_DESEL, 16'h0000);
            1:       word = cmd_word(OP_PRE,   ARG_PRE_ALL);
            2:       word = cmd_word(OP_EMRS2, 16'h0000);
            3:       word = cmd_word(OP_EMRS3, 16'h0000);
            4:       word = cmd_word(OP_EMRS,  ARG_DLL_EN);
            5:       word = cmd_word(OP_MRS,   ARG_DLL_RST);
            6:       word = cmd_word(OP_PRE,   ARG_PRE_ALL);
            7:       word = cmd_word(OP_REF,   16'h0000);
            8:       word = cmd_word(OP_REF,   16'h0000);
            9:       word = cmd_word(OP_MRS,   mode_cfg[15:0]);
            10:      word = cmd_word(OP_EMRS,  ARG_OCD_DFLT | ARG_DLL_EN);
            11:      word = cmd_word(OP_EMRS,  final_arg);
            default: word = cmd_word(OP_DESEL, 16'h0000);
        endcase
    end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int          WAIT_CYCLES = 50000,
    parameter logic [31:0] BASE_ADDR   = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        bus_ready,
    input  logic [31:0] mode_cfg,
    input  logic [31:0] timing_cfg,
    input  logic [31:0] latency_cfg,
    input  logic [31:0] ctrl_cfg,
    output logic        wr_en,
    output logic [31:0] wr_addr,
    output logic [31:0] wr_data,
    output logic        done
);
    localparam int CIDX_W = $clog2(NUM_CMDS);
    localparam logic [CIDX_W-1:0] LAST_CMD = CIDX_W'(NUM_CMDS - 1);
    localparam logic [31:0] PHY_RST_WORD = (32'd1 << PHY_RST_BIT) | (32'd1 << CAL_RST_BIT);
    localparam logic [31:0] CAL_WORD     = 32'd1 << CAL_START_BIT;

    seq_state_t state, state_nx;
    logic [CIDX_W-1:0] cmd_idx;
    logic [31:0] cmd_data;
    logic wait_run, wait_exp, accept;

    assign wait_run = (state == ST_WAIT_CLK) || (state == ST_WAIT_PHY) ||
                      (state == ST_WAIT_CAL) || (state == ST_WAIT_CMD);
    assign accept   = wr_en && bus_ready;

    ddr2_init_wait #(.WAIT_CYCLES(WAIT_CYCLES)) i_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (wait_run),
        .expired (wait_exp)
    );

    ddr2_init_script #(.IDX_W(CIDX_W)) i_script (
        .idx      (cmd_idx),
        .mode_cfg (mode_cfg),
        .word     (cmd_data)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT_CLK: if (wait_exp) state_nx = ST_CLK_ON;
            ST_CLK_ON:   if (bus_ready) state_nx = ST_WAIT_PHY;
            ST_WAIT_PHY: if (wait_exp) state_nx = ST_PHY_RST;
            ST_PHY_RST:  if (bus_ready) state_nx = ST_PHY_CAL;
            ST_PHY_CAL:  if (bus_ready) state_nx = ST_WAIT_CAL;
            ST_WAIT_CAL: if (wait_exp) state_nx = ST_CMD;
            ST_CMD:      if (bus_ready) state_nx = ST_WAIT_CMD;
            ST_WAIT_CMD: if (wait_exp) state_nx = (cmd_idx == LAST_CMD) ? ST_TIMING : ST_CMD;
            ST_TIMING:   if (bus_ready) state_nx = ST_LATENCY;
            ST_LATENCY:  if (bus_ready) state_nx = ST_CONFIG;
            ST_CONFIG:   if (bus_ready) state_nx = ST_DONE;
            ST_DONE:     if (start) state_nx = ST_WAIT_CLK;
            default:     state_nx = ST_WAIT_CLK;
        endcase
    end

    // State and command index registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_WAIT_CLK;
            cmd_idx <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_WAIT_CAL)
                cmd_idx <= '0;
            else if (state == ST_WAIT_CMD && wait_exp && cmd_idx != LAST_CMD)
                cmd_idx <= cmd_idx + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        done    = 1'b0;
        unique case (state)
            ST_CLK_ON: begin
                wr_en = 1'b1; wr_addr = BASE_ADDR + OFF_CLK_EN;
                wr_data = 32'd1 << CLK_EN_BIT;
            end
            ST_PHY_RST: begin
                wr_en = 1'b1; wr_addr = BASE_ADDR + OFF_PHY_CTRL; wr_data = PHY_RST_WORD;
            end
            ST_PHY_CAL: begin
                wr_en = 1'b1; wr_addr = BASE_ADDR + OFF_PHY_CTRL; wr_data = CAL_WORD;
            end
            ST_CMD: begin
                wr_en = 1'b1; wr_addr = BASE_ADDR + OFF_CMD; wr_data = cmd_data;
            end
            ST_TIMING: begin
                wr_en = 1'b1; wr_addr = BASE_ADDR + OFF_TIMING; wr_data = timing_cfg;
            end
            ST_LATENCY: begin
                wr_en = 1'b1; wr_addr = BASE_ADDR + OFF_LATENCY; wr_data = latency_cfg;
            end
            ST_CONFIG: begin
                wr_en = 1'b1; wr_addr = BASE_ADDR + OFF_CONFIG; wr_data = ctrl_cfg;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    // R9: a stalled write is held unchanged
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !bus_ready) |=> (wr_en && $stable(wr_addr) && $stable(wr_data)));

    // R3: calibration start follows the PHY reset write on the next cycle
    a_r3_phy_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && wr_addr == BASE_ADDR + OFF_PHY_CTRL && wr_data == PHY_RST_WORD)
        |=> (wr_en && wr_addr == BASE_ADDR + OFF_PHY_CTRL && wr_data == CAL_WORD));

    // R8: the latency write follows the accepted timing write
    a_r8_timing_then_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && wr_addr == BASE_ADDR + OFF_TIMING) |=> (wr_en && wr_addr == BASE_ADDR + OFF_LATENCY));

    // R10: done is sticky without start
    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R10: no writes once done
    a_r10_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_en);

    // R4: command words keep their top byte clear
    a_r4_cmd_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == BASE_ADDR + OFF_CMD) |-> (wr_data[31:24] == 8'h00));

endmodule

// File: tb/test_ddr2_init_seq.sv
module test_ddr2_init_seq;

    localparam int          W    = 20;
    localparam logic [31:0] BASE = 32'h8000_0000;
    localparam logic [31:0] MODE = 32'h00A5_0642;
    localparam logic [31:0] TIM  = 32'h1234_5678;
    localparam logic [31:0] LAT  = 32'h0000_0035;
    localparam logic [31:0] CFG  = 32'hCAFE_0011;
    localparam int NVEC = 18;
    localparam int WATCHDOG = 100000;

    // Gap kinds: 0 = first write, 1 = after a wait, 2 = back-to-back
    localparam logic [65:0] VEC [NVEC] = '{
        {2'd0, BASE + 32'h00, 32'h0000_0001},   // R2
        {2'd1, BASE + 32'h04, 32'h0000_0003},   // R3
        {2'd2, BASE + 32'h04, 32'h0000_0004},   // R3
        {2'd1, BASE + 32'h08, 32'h0000_0000},   // R5 deselect
        {2'd1, BASE + 32'h08, 32'h0001_0400},   // R5 precharge all
        {2'd1, BASE + 32'h08, 32'h0005_0000},   // R5 EMRS2
        {2'd1, BASE + 32'h08, 32'h0006_0000},   // R5 EMRS3
        {2'd1, BASE + 32'h08, 32'h0004_0001},   // R5 EMRS DLL enable
        {2'd1, BASE + 32'h08, 32'h0003_0100},   // R5 MRS DLL reset
        {2'd1, BASE + 32'h08, 32'h0001_0400},   // R5 precharge all
        {2'd1, BASE + 32'h08, 32'h0002_0000},   // R5 refresh
        {2'd1, BASE + 32'h08, 32'h0002_0000},   // R5 refresh
        {2'd1, BASE + 32'h08, 32'h0003_0642},   // R6 MRS mode
        {2'd1, BASE + 32'h08, 32'h0004_0381},   // R5 OCD default
        {2'd1, BASE + 32'h08, 32'h0004_02A5},   // R6 OCD exit
        {2'd1, BASE + 32'h0C, TIM},             // R8
        {2'd2, BASE + 32'h10, LAT},             // R8
        {2'd2, BASE + 32'h14, CFG}              // R8
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic bus_ready = 1'b1;
    logic wr_en, done;
    logic [31:0] wr_addr, wr_data;
    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    ddr2_init_seq #(.WAIT_CYCLES(W), .BASE_ADDR(BASE)) i_ddr2_init_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .bus_ready(bus_ready),
        .mode_cfg(MODE), .timing_cfg(TIM), .latency_cfg(LAT), .ctrl_cfg(CFG),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
    );

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles, expected below %0d", cyc, WATCHDOG);
            report();
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Walk the vector table. first_gap: edges before the first write.
    // stall_idx: vector held off with bus_ready low. start_idx: vector whose
    // following wait sees a start pulse.
    task automatic run_seq(input int first_gap, input int stall_idx, input int start_idx);
        for (int k = 0; k < NVEC; k++) begin
            int gap = 0;
            int exp_gap;
            do begin
                @(negedge clk);
                gap++;
                start = (k == start_idx && gap == 2);
            end while (!wr_en && gap < 4 * W);
            start = 1'b0;
            exp_gap = (VEC[k][65:64] == 2'd0) ? first_gap : (VEC[k][65:64] == 2'd1) ? W + 1 : 1;
            check(k == 0 ? "R1 first delay" : "R7 write spacing", 64'(gap), 64'(exp_gap));
            check("R4/R5 address", 64'(wr_addr), 64'(VEC[k][63:32]));
            check("R5/R6 data", 64'(wr_data), 64'(VEC[k][31:0]));
            check("R10 done low while running", 64'(done), 64'd0);
            if (k == stall_idx) begin
                bus_ready = 1'b0;
                for (int s = 0; s < 3; s++) begin
                    @(negedge clk);
                    check("R9 stalled write held", {31'd0, wr_en, wr_addr}, {31'd0, 1'b1, VEC[k][63:32]});
                    check("R9 stalled data held", 64'(wr_data), 64'(VEC[k][31:0]));
                end
                bus_ready = 1'b1;
            end
        end
        @(negedge clk);
        check("R10 done after config", {62'd0, done, wr_en}, {62'd0, 1'b1, 1'b0});
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset wr_en", 64'(wr_en), 64'd0);
        check("R1 reset done", 64'(done), 64'd0);
        rst_n = 1'b1;

        // Run 1: plain sequence, stall on the MRS mode command
        run_seq(W, 12, -1);

        // R10: done held, no writes
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!done || wr_en) check("R10 idle after done", {62'd0, done, wr_en}, {62'd0, 1'b1, 1'b0});
        end
        n_chk++;

        // R11: rerun by start, with start pulsed mid-run (ignored)
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R11 done drops on start", 64'(done), 64'd0);
        run_seq(W, 1, 5);

        // R1: reset in the middle of a run
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (W + 5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset quiet", {62'd0, done, wr_en}, 64'd0);
        rst_n = 1'b1;
        run_seq(W, 16, -1);

        report();
    end

endmodule